// File: doc/BRIEF.md
# D-Channel Access Arbiter

This block sits in a terminal-side transceiver. On one side is a framed serial link to the terminal. On the other side is a line-side controller that grants or refuses use of one HDLC receiver shared by several subscribers. Once per frame, on the frame strobe, the block samples two things from the terminal: an access-request bit (1 = idle, 0 = wants the receiver) and the terminal's D-channel bits. It then drives a stop/go flag back to the terminal and the D-channel bits sent upstream.

To claim the shared receiver, the block sends zeros upstream while the request is pending. After a grant it keeps sending zeros until the terminal's own first zero bit appears, which marks the start of a real HDLC frame. From that bit on, the D-channel passes through unchanged. A terminal may therefore wait any number of frames after the grant without sending all-ones, which the far end would read as an abort.

A flag-fill configuration code switches the zero forcing off and leaves the stop/go control in place. The D-channel stream moves at one word per frame strobe. It has no valid/ready handshake and no back-pressure: the frame timing paces both ends, and a word that is not taken at its strobe is replaced by the next one. The grant and deny lines are plain pulses.

Top module: `dch_access_arb`

## Requirements
- R1: On a frame strobe with the request bit at 1, the block enters idle (state code 0) and stop/go reads 1 (stop) from the next cycle on. In idle, the upstream D-channel equals the D-channel word sampled at that strobe.
- R2: On a frame strobe with the request bit at 0 while idle, the block enters requesting (state code 1). Upstream D-channel bits become all zero and stop/go stays 1. The block remains in requesting, still forcing zeros, at every later strobe until a grant has been taken.
- R3: A grant pulse in any cycle while requesting is held until the next frame strobe. At that strobe (request bit still 0) the block enters granted-holding (state code 2) and stop/go reads 0 (go). A deny pulse drops any held grant, and deny wins when both pulses arrive in the same cycle, so the block stays in requesting with stop/go at 1.
- R4: In granted-holding, upstream bits stay all zero while the sampled word is all ones. At the first strobe whose word holds a 0, the block enters transparent (state code 3). Bit D_BITS-1 is sent first, so the bits ahead of the first 0 are sent as 0 and the bits from that 0 onward pass through unchanged.
- R5: In transparent, the upstream D-channel equals the sampled word, ones included, and stop/go stays 0.
- R6: A strobe that samples the request bit at 1 in any state returns the block to idle. Stop/go goes to 1 and the D-channel is transparent from that strobe on.
- R7: A grant pulse that arrives when the block is not requesting is ignored. A later request still waits in requesting with stop/go at 1.
- R8: When cfg_mode equals FILL_CODE (default 3'b101), the upstream D-channel always equals the sampled word. The state sequence and stop/go follow R1 to R7 unchanged.
- R9: sg_out, up_d and state_out change only on a clock edge where frame_stb is 1.
- R10: A synchronous active-high reset puts the block in idle with stop/go at 1 and up_d at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle pulse marking the sampling slot of each frame |
| req_bit | input | 1 | Access request from the terminal, 0 = request |
| term_d | input | D_BITS | D-channel bits from the terminal, MSB sent first |
| grant | input | 1 | One-cycle grant pulse from the line side |
| deny | input | 1 | One-cycle deny pulse from the line side |
| cfg_mode | input | CFG_W | Configuration code; FILL_CODE selects flag-fill operation |
| sg_out | output | 1 | Stop/go to the terminal, 1 = stop |
| up_d | output | D_BITS | D-channel bits sent upstream |
| state_out | output | 2 | Current state: 0 idle, 1 requesting, 2 granted-holding, 3 transparent |

## Verification
The bench uses the default parameters: two D-channel bits per frame, a three-bit configuration field and fill code 3'b101. With two bits per frame it can reach both outcomes of the first-zero rule: the words 10, where the leading one is sent as zero, and 01, where the word passes whole. It also covers a grant held across non-strobe cycles, a grant and a deny arriving together, and a grant that arrives while idle. The same request and grant sequences are run with and without the fill code, so the bench can check that forcing is turned off while stop/go is not affected.

// File: rtl/dch_arb_pkg.sv
package dch_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_HOLD = 2'd2,
    ST_PASS = 2'd3
  } arb_st_e;

  function automatic logic st_granted(arb_st_e s);
    return (s == ST_HOLD) || (s == ST_PASS);
  endfunction
endpackage

// File: rtl/dch_grant_latch.sv
module dch_grant_latch (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  input  logic in_ask,
  input  logic grant,
  input  logic deny,
  output logic grant_take
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst || frame_stb || deny) pend <= 1'b0;
    else if (grant && in_ask)     pend <= 1'b1;
  end

  assign grant_take = in_ask && !deny && (pend || grant);

  AST_GRANT_ONLY_WHILE_ASKING: assert property (@(posedge clk) disable iff (rst)
    !in_ask |-> !pend); // R7
  AST_DENY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    deny |=> !pend); // R3
endmodule

// File: rtl/dch_arb_fsm.sv
module dch_arb_fsm
  import dch_arb_pkg::*;
#(
  parameter int D_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              req_bit,
  input  logic [D_BITS-1:0] term_d,
  input  logic              grant_take,
  output arb_st_e           st,
  output arb_st_e           st_nxt
);
  logic has_zero;
  assign has_zero = !(&term_d);

  always_comb begin
    st_nxt = st;
    if (frame_stb) begin
      if (req_bit) st_nxt = ST_IDLE;
      else begin
        unique case (st)
          ST_IDLE: st_nxt = ST_ASK;
          ST_ASK:  st_nxt = grant_take ? ST_HOLD : ST_ASK;
          ST_HOLD: st_nxt = has_zero ? ST_PASS : ST_HOLD;
          ST_PASS: st_nxt = ST_PASS;
          default: st_nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  AST_IDLE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    frame_stb && req_bit |=> st == ST_IDLE); // R6
  AST_ASK_WAITS: assert property (@(posedge clk) disable iff (rst)
    st == ST_ASK && frame_stb && !req_bit && !grant_take |=> st == ST_ASK); // R2
  AST_HOLD_ON_ONES: assert property (@(posedge clk) disable iff (rst)
    st == ST_HOLD && frame_stb && !req_bit && (&term_d) |=> st == ST_HOLD); // R4
endmodule

// File: rtl/dch_arb_dpath.sv
module dch_arb_dpath
  import dch_arb_pkg::*;
#(
  parameter int D_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  arb_st_e           st,
  input  arb_st_e           st_nxt,
  input  logic [D_BITS-1:0] term_d,
  input  logic              fill_mode,
  output logic              sg_out,
  output logic [D_BITS-1:0] up_d
);
  logic [D_BITS-1:0] lead_ones;
  logic [D_BITS-1:0] d_nxt;

  for (genvar i = 0; i < D_BITS; i++) begin : g_lead
    assign lead_ones[i] = &term_d[D_BITS-1:i];
  end

  always_comb begin
    d_nxt = term_d;
    if (!fill_mode) begin
      if (st_nxt == ST_ASK || st_nxt == ST_HOLD) d_nxt = '0;
      else if (st_nxt == ST_PASS && st == ST_HOLD) d_nxt = term_d & ~lead_ones;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sg_out <= 1'b1;
      up_d   <= '1;
    end else if (frame_stb) begin
      sg_out <= !st_granted(st_nxt);
      up_d   <= d_nxt;
    end
  end

  AST_STOP_UNLESS_GRANTED: assert property (@(posedge clk) disable iff (rst)
    !sg_out |-> st_granted(st)); // R3
  AST_ASK_FORCES_ZERO: assert property (@(posedge clk) disable iff (rst)
    !fill_mode && frame_stb && st_nxt == ST_ASK |=> up_d == '0); // R2
  AST_PASS_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    frame_stb && st == ST_PASS && st_nxt == ST_PASS |=> up_d == $past(term_d)); // R5
  AST_FILL_NO_FORCE: assert property (@(posedge clk) disable iff (rst)
    fill_mode && frame_stb |=> up_d == $past(term_d)); // R8
endmodule

// File: rtl/dch_access_arb.sv
module dch_access_arb
  import dch_arb_pkg::*;
#(
  parameter int             D_BITS    = 2,
  parameter int             CFG_W     = 3,
  parameter logic [CFG_W-1:0] FILL_CODE = 3'b101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic              req_bit,
  input  logic [D_BITS-1:0] term_d,
  input  logic              grant,
  input  logic              deny,
  input  logic [CFG_W-1:0]  cfg_mode,
  output logic              sg_out,
  output logic [D_BITS-1:0] up_d,
  output logic [1:0]        state_out
);
  arb_st_e st, st_nxt;
  logic    grant_take;
  logic    fill_mode;

  assign fill_mode = (cfg_mode == FILL_CODE);
  assign state_out = st;

  dch_grant_latch u_latch (
    .clk(clk), .rst(rst), .frame_stb(frame_stb),
    .in_ask(st == ST_ASK), .grant(grant), .deny(deny),
    .grant_take(grant_take)
  );

  dch_arb_fsm #(.D_BITS(D_BITS)) u_fsm (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .req_bit(req_bit),
    .term_d(term_d), .grant_take(grant_take), .st(st), .st_nxt(st_nxt)
  );

  dch_arb_dpath #(.D_BITS(D_BITS)) u_dpath (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .st(st), .st_nxt(st_nxt),
    .term_d(term_d), .fill_mode(fill_mode), .sg_out(sg_out), .up_d(up_d)
  );

  AST_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(sg_out) && $stable(up_d) && $stable(state_out)); // R9
  AST_IDLE_STOP: assert property (@(posedge clk) disable iff (rst)
    frame_stb && req_bit |=> sg_out); // R1
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> state_out == 2'd0 && sg_out && up_d == '1); // R10
endmodule

// File: tb/tb_dch_access_arb.sv
module tb_dch_access_arb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0;
  logic       req_bit = 1'b1;
  logic [1:0] term_d = 2'b11;
  logic       grant = 1'b0;
  logic       deny = 1'b0;
  logic [2:0] cfg_mode = 3'b000;
  logic       sg_out;
  logic [1:0] up_d;
  logic [1:0] state_out;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  dch_access_arb dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .req_bit(req_bit),
    .term_d(term_d), .grant(grant), .deny(deny), .cfg_mode(cfg_mode),
    .sg_out(sg_out), .up_d(up_d), .state_out(state_out)
  );

  // {fill, req, term_d, grant, deny, exp_state, exp_sg, exp_up}
  localparam int NV = 22;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0,1'b1,2'b11,1'b0,1'b0,2'd0,1'b1,2'b11}, // R1
    {1'b0,1'b1,2'b01,1'b0,1'b0,2'd0,1'b1,2'b01}, // R1
    {1'b0,1'b0,2'b11,1'b0,1'b0,2'd1,1'b1,2'b00}, // R2
    {1'b0,1'b0,2'b01,1'b0,1'b0,2'd1,1'b1,2'b00}, // R2
    {1'b0,1'b0,2'b11,1'b1,1'b0,2'd2,1'b0,2'b00}, // R3
    {1'b0,1'b0,2'b11,1'b0,1'b0,2'd2,1'b0,2'b00}, // R4
    {1'b0,1'b0,2'b10,1'b0,1'b0,2'd3,1'b0,2'b00}, // R4
    {1'b0,1'b0,2'b11,1'b0,1'b0,2'd3,1'b0,2'b11}, // R5
    {1'b0,1'b0,2'b01,1'b0,1'b0,2'd3,1'b0,2'b01}, // R5
    {1'b0,1'b1,2'b11,1'b0,1'b0,2'd0,1'b1,2'b11}, // R6
    {1'b0,1'b1,2'b11,1'b1,1'b0,2'd0,1'b1,2'b11}, // R7
    {1'b0,1'b0,2'b11,1'b0,1'b0,2'd1,1'b1,2'b00}, // R7
    {1'b0,1'b0,2'b11,1'b1,1'b1,2'd1,1'b1,2'b00}, // R3
    {1'b0,1'b0,2'b11,1'b0,1'b1,2'd1,1'b1,2'b00}, // R3
    {1'b0,1'b0,2'b11,1'b1,1'b0,2'd2,1'b0,2'b00}, // R3
    {1'b0,1'b0,2'b01,1'b0,1'b0,2'd3,1'b0,2'b01}, // R4
    {1'b0,1'b1,2'b10,1'b0,1'b0,2'd0,1'b1,2'b10}, // R6
    {1'b1,1'b1,2'b11,1'b0,1'b0,2'd0,1'b1,2'b11}, // R8
    {1'b1,1'b0,2'b11,1'b0,1'b0,2'd1,1'b1,2'b11}, // R8
    {1'b1,1'b0,2'b11,1'b1,1'b0,2'd2,1'b0,2'b11}, // R8
    {1'b1,1'b0,2'b10,1'b0,1'b0,2'd3,1'b0,2'b10}, // R8
    {1'b1,1'b1,2'b11,1'b0,1'b0,2'd0,1'b1,2'b11}  // R8
  };

  task automatic check(input string tag, input logic [1:0] st,
                       input logic sg, input logic [1:0] ud);
    checks++;
    if (state_out !== st || sg_out !== sg || up_d !== ud) begin
      fails++;
      $display("FAIL %s: state=%0d sg=%0b up=%02b expected state=%0d sg=%0b up=%02b",
               tag, state_out, sg_out, up_d, st, sg, ud);
    end
  endtask

  task automatic pulse(input logic g, input logic d);
    @(negedge clk); grant = g; deny = d;
    @(negedge clk); grant = 1'b0; deny = 1'b0;
  endtask

  task automatic frame(input logic rq, input logic [1:0] td);
    @(negedge clk); req_bit = rq; term_d = td; frame_stb = 1'b1;
    @(negedge clk); frame_stb = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", 2'd0, 1'b1, 2'b11);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after release", 2'd0, 1'b1, 2'b11);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      cfg_mode = v[10] ? 3'b101 : 3'b000;
      if (v[6] || v[5]) pulse(v[6], v[5]);
      frame(v[9], v[8:7]);
      check($sformatf("vector %0d (R1..R8 table)", i), v[4:3], v[2], v[1:0]);
    end

    // R9: no strobe, inputs move, outputs hold
    cfg_mode = 3'b000;
    frame(1'b0, 2'b11);
    check("R2 directed ask", 2'd1, 1'b1, 2'b00);
    pulse(1'b1, 1'b0);
    @(negedge clk); req_bit = 1'b1; term_d = 2'b01;
    repeat (4) @(negedge clk);
    check("R9 hold between strobes", 2'd1, 1'b1, 2'b00);
    frame(1'b0, 2'b11);
    check("R3 grant held across cycles", 2'd2, 1'b0, 2'b00);
    frame(1'b0, 2'b00);
    check("R4 zero word passes", 2'd3, 1'b0, 2'b00);

    // R10: reset from transparent
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 reset mid-frame", 2'd0, 1'b1, 2'b11);
    rst = 1'b0;
    frame(1'b0, 2'b11);
    check("R2 ask after reset", 2'd1, 1'b1, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule